// File: doc/BRIEF.md
# Weighted Deficit Round Robin Queue Manager

This block manages the output queues of a single egress interface. Each arriving packet descriptor carries a queue number, a byte length and a buffer handle. Payload bytes never enter the block. An accepted descriptor is appended to the tail of its queue's linked list, which lives in a shared pool of descriptor slots. A descriptor is refused when its queue would hold more bytes than the configured discard threshold, or when the pool has no free slot. A refused descriptor is returned on a drop port one cycle later, so that whoever owns its buffer can reclaim it.

A single weighted deficit round robin scheduler serves the queues of this interface. It visits the non-empty queues in a circular order and gives each queue its quantum of credit on every visit. It hands out head descriptors while they fit in the accumulated credit. Departures use a valid/ready handshake. Quantum and threshold can be written per queue through a simple write port. A field code selects which of the two values is written.

The scheduler has three named states. In IDLE it looks for the next non-empty queue after the current one (IDLE to CREDIT when any queue holds data, otherwise it stays in IDLE). In CREDIT it adds the quantum to that queue's deficit (always CREDIT to OFFER). In OFFER it presents the head descriptor while the head fits. OFFER stays in OFFER while the head fits and the queue keeps data. OFFER goes back to IDLE when the head no longer fits, or when the last descriptor leaves and the deficit is cleared.

Top module: `wdrr_qmgr`

## Requirements
- R1: After reset `deq_valid` and `drop_valid` are low. Every quantum resets to `DEF_QUANTUM` and every threshold resets to `DEF_THRESH`.
- R2: An arrival is accepted only if its queue's stored byte count plus the arrival length is no more than that queue's threshold. Equality is accepted.
- R3: A refused arrival sets `drop_valid` on the next cycle, with its handle, queue and length. `drop_valid` is never high without an arrival in the previous cycle.
- R4: When all `DEPTH` descriptor slots are occupied, any further arrival is refused. Free slots plus stored descriptors always equal `DEPTH`.
- R5: Descriptors of one queue leave in the order they were accepted.
- R6: Each visit adds the queue's quantum to its deficit. The head descriptor is offered only while its length is no more than the deficit, and each departure subtracts its length from the deficit.
- R7: When a queue's last descriptor leaves, its deficit is cleared to zero and the scheduler moves on. An empty queue is never offered, and with all queues empty `deq_valid` stays low.
- R8: When the head length exceeds the remaining deficit, the scheduler keeps that deficit and moves to the next non-empty queue in ascending circular order. The search starts after the current queue.
- R9: While `deq_valid` is high and `deq_ready` is low, `deq_valid`, `deq_qid`, `deq_len` and `deq_hdl` hold. Exactly one descriptor leaves per cycle with both high.
- R10: A write with `cfg_field` = 0 sets the quantum of `cfg_qid` from the low `QNT_W` bits of `cfg_data`. A write with `cfg_field` = 1 sets its threshold from `cfg_data`. Later decisions use the new value.
- R11: A queue's byte count is the sum of the lengths it holds. It falls by the departing length, and an empty queue counts zero bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_valid | input | 1 | Arrival present this cycle |
| enq_qid | input | QW | Target queue of the arrival |
| enq_len | input | LEN_W | Packet length in bytes |
| enq_hdl | input | HDL_W | Buffer handle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 1 | 0 = quantum, 1 = threshold |
| cfg_qid | input | QW | Queue being configured |
| cfg_data | input | BYTE_W | Value written |
| deq_valid | output | 1 | Head descriptor offered |
| deq_ready | input | 1 | Downstream takes the offered descriptor |
| deq_qid | output | QW | Queue of the offered descriptor |
| deq_len | output | LEN_W | Length of the offered descriptor |
| deq_hdl | output | HDL_W | Handle of the offered descriptor |
| drop_valid | output | 1 | A refused arrival is returned |
| drop_qid | output | QW | Queue of the refused arrival |
| drop_len | output | LEN_W | Length of the refused arrival |
| drop_hdl | output | HDL_W | Handle of the refused arrival |

## Verification
A directed threshold pattern fills one queue to exactly its limit and one byte beyond. This separates an inclusive admission compare from an exclusive one, and a second round confirms that the bytes come back after a drain. An overfill pattern with generous thresholds isolates refusals caused by the slot pool. A hand-picked mix of quanta and lengths forces heads that need two visits. Randomised rounds with random quanta, thresholds and lengths, drained under random backpressure, compare the whole departure order against a bench model. That comparison tells apart errors in credit accounting, queue rotation, deficit clearing and per-queue ordering.

// File: rtl/wdrr_pkg.sv
package wdrr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CREDIT = 2'd1,
        ST_OFFER  = 2'd2
    } sched_state_e;

    typedef enum logic [1:0] {
        DA_KEEP = 2'd0,
        DA_ADD  = 2'd1,
        DA_SUB  = 2'd2,
        DA_ZERO = 2'd3
    } deficit_act_e;

    localparam logic FIELD_QUANTUM = 1'b0;
    localparam logic FIELD_THRESH  = 1'b1;

endpackage

// File: rtl/wdrr_cfg_regs.sv
module wdrr_cfg_regs #(
    parameter int NQ          = 4,
    parameter int QW          = 2,
    parameter int QNT_W       = 10,
    parameter int BYTE_W      = 16,
    parameter int DEF_QUANTUM = 64,
    parameter int DEF_THRESH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_field,
    input  logic [QW-1:0]     wr_qid,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [QNT_W-1:0]  quantum [NQ],
    output logic [BYTE_W-1:0] thresh  [NQ]
);
    import wdrr_pkg::*;

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic hit;
        assign hit = wr_en && (wr_qid == QW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                quantum[g] <= QNT_W'(DEF_QUANTUM);
                thresh[g]  <= BYTE_W'(DEF_THRESH);
            end else if (hit) begin
                if (wr_field == FIELD_QUANTUM) begin
                    quantum[g] <= wr_data[QNT_W-1:0];
                end else begin
                    thresh[g] <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/wdrr_desc_store.sv
module wdrr_desc_store #(
    parameter int NQ     = 4,
    parameter int QW     = 2,
    parameter int DEPTH  = 16,
    parameter int PW     = 4,
    parameter int CW     = 5,
    parameter int LEN_W  = 11,
    parameter int HDL_W  = 10,
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [QW-1:0]     push_qid,
    input  logic [LEN_W-1:0]  push_len,
    input  logic [HDL_W-1:0]  push_hdl,
    input  logic              pop,
    input  logic [QW-1:0]     pop_qid,
    output logic [LEN_W-1:0]  head_len [NQ],
    output logic [HDL_W-1:0]  head_hdl [NQ],
    output logic [CW-1:0]     q_pkts   [NQ],
    output logic [BYTE_W-1:0] q_bytes  [NQ],
    output logic [DEPTH-1:0]  free_map,
    output logic              full
);
    logic [PW-1:0]    nxt      [DEPTH];
    logic [LEN_W-1:0] slot_len [DEPTH];
    logic [HDL_W-1:0] slot_hdl [DEPTH];
    logic [PW-1:0]    head_ptr [NQ];
    logic [PW-1:0]    tail_ptr [NQ];
    logic [PW-1:0]    alloc;
    logic             link;

    // lowest free slot is handed to the next accepted arrival
    always_comb begin
        alloc = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_map[i]) alloc = PW'(i);
        end
    end

    assign full = ~|free_map;

    // append behind the tail unless the queue is empty, or its only entry leaves now
    assign link = (q_pkts[push_qid] != '0) &&
                  !(pop && (pop_qid == push_qid) && (q_pkts[push_qid] == CW'(1)));

    for (genvar g = 0; g < NQ; g++) begin : g_head
        assign head_len[g] = slot_len[head_ptr[g]];
        assign head_hdl[g] = slot_hdl[head_ptr[g]];
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_len[alloc] <= push_len;
            slot_hdl[alloc] <= push_hdl;
            if (link) nxt[tail_ptr[push_qid]] <= alloc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_map <= '1;
            for (int q = 0; q < NQ; q++) begin
                head_ptr[q] <= '0;
                tail_ptr[q] <= '0;
            end
        end else begin
            if (pop) begin
                free_map[head_ptr[pop_qid]] <= 1'b1;
                head_ptr[pop_qid]           <= nxt[head_ptr[pop_qid]];
            end
            if (push) begin
                free_map[alloc]    <= 1'b0;
                tail_ptr[push_qid] <= alloc;
                if (!link) head_ptr[push_qid] <= alloc;
            end
        end
    end

    for (genvar g = 0; g < NQ; g++) begin : g_cnt
        logic push_hit;
        logic pop_hit;
        assign push_hit = push && (push_qid == QW'(g));
        assign pop_hit  = pop  && (pop_qid  == QW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_pkts[g]  <= '0;
                q_bytes[g] <= '0;
            end else begin
                q_pkts[g]  <= q_pkts[g] + CW'(push_hit) - CW'(pop_hit);
                q_bytes[g] <= q_bytes[g]
                            + (push_hit ? BYTE_W'(push_len)    : '0)
                            - (pop_hit  ? BYTE_W'(head_len[g]) : '0);
            end
        end
    end

endmodule

// File: rtl/wdrr_sched.sv
module wdrr_sched #(
    parameter int NQ    = 4,
    parameter int QW    = 2,
    parameter int LEN_W = 11,
    parameter int QNT_W = 10,
    parameter int DEF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    q_nonempty,
    input  logic [NQ-1:0]    q_last,
    input  logic [LEN_W-1:0] head_len [NQ],
    input  logic [QNT_W-1:0] quantum  [NQ],
    input  logic             push,
    input  logic [QW-1:0]    push_qid,
    input  logic             deq_ready,
    output logic [QW-1:0]    cur,
    output logic             deq_valid,
    output logic             pop
);
    import wdrr_pkg::*;

    sched_state_e     state_q, state_d;
    logic [QW-1:0]    cur_q, cur_d, pick;
    logic [DEF_W-1:0] deficit [NQ];
    deficit_act_e     act;
    logic             fits;

    // next non-empty queue after the current one, circular
    always_comb begin
        pick = cur_q;
        for (int i = NQ; i >= 1; i--) begin
            if (q_nonempty[(int'(cur_q) + i) % NQ]) pick = QW'((int'(cur_q) + i) % NQ);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // outputs
    always_comb begin
        fits      = DEF_W'(head_len[cur_q]) <= deficit[cur_q];
        deq_valid = (state_q == ST_OFFER) && q_nonempty[cur_q] && fits;
        pop       = deq_valid && deq_ready;
        cur       = cur_q;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        act     = DA_KEEP;
        unique case (state_q)
            ST_IDLE: begin
                if (|q_nonempty) begin
                    cur_d   = pick;
                    state_d = ST_CREDIT;
                end
            end
            ST_CREDIT: begin
                act     = DA_ADD;
                state_d = ST_OFFER;
            end
            ST_OFFER: begin
                if (!q_nonempty[cur_q]) begin
                    act     = DA_ZERO;
                    state_d = ST_IDLE;
                end else if (!fits) begin
                    state_d = ST_IDLE;
                end else if (deq_ready) begin
                    if (q_last[cur_q] && !(push && (push_qid == cur_q))) begin
                        act     = DA_ZERO;
                        state_d = ST_IDLE;
                    end else begin
                        act = DA_SUB;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    for (genvar g = 0; g < NQ; g++) begin : g_def
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                deficit[g] <= '0;
            end else if (cur_q == QW'(g)) begin
                unique case (act)
                    DA_ADD:  deficit[g] <= deficit[g] + DEF_W'(quantum[g]);
                    DA_SUB:  deficit[g] <= deficit[g] - DEF_W'(head_len[g]);
                    DA_ZERO: deficit[g] <= '0;
                    default: deficit[g] <= deficit[g];
                endcase
            end
        end
    end

endmodule

// File: rtl/wdrr_qmgr.sv
module wdrr_qmgr #(
    parameter int NQ          = 4,
    parameter int DEPTH       = 16,
    parameter int LEN_W       = 11,
    parameter int HDL_W       = 10,
    parameter int QNT_W       = 10,
    parameter int BYTE_W      = 16,
    parameter int DEF_QUANTUM = 64,
    parameter int DEF_THRESH  = 1024,
    localparam int QW         = $clog2(NQ),
    localparam int PW         = $clog2(DEPTH),
    localparam int CW         = $clog2(DEPTH + 1),
    localparam int DEF_W      = ((LEN_W > QNT_W) ? LEN_W : QNT_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [QW-1:0]     enq_qid,
    input  logic [LEN_W-1:0]  enq_len,
    input  logic [HDL_W-1:0]  enq_hdl,
    input  logic              cfg_we,
    input  logic              cfg_field,
    input  logic [QW-1:0]     cfg_qid,
    input  logic [BYTE_W-1:0] cfg_data,
    output logic              deq_valid,
    input  logic              deq_ready,
    output logic [QW-1:0]     deq_qid,
    output logic [LEN_W-1:0]  deq_len,
    output logic [HDL_W-1:0]  deq_hdl,
    output logic              drop_valid,
    output logic [QW-1:0]     drop_qid,
    output logic [LEN_W-1:0]  drop_len,
    output logic [HDL_W-1:0]  drop_hdl
);
    logic [QNT_W-1:0]  quantum  [NQ];
    logic [BYTE_W-1:0] thresh   [NQ];
    logic [LEN_W-1:0]  head_len [NQ];
    logic [HDL_W-1:0]  head_hdl [NQ];
    logic [CW-1:0]     q_pkts   [NQ];
    logic [BYTE_W-1:0] q_bytes  [NQ];
    logic [DEPTH-1:0]  free_map;
    logic              full;
    logic [NQ-1:0]     q_nonempty, q_last;
    logic              accept, pop;
    logic [QW-1:0]     cur;

    wdrr_cfg_regs #(
        .NQ(NQ), .QW(QW), .QNT_W(QNT_W), .BYTE_W(BYTE_W),
        .DEF_QUANTUM(DEF_QUANTUM), .DEF_THRESH(DEF_THRESH)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_field(cfg_field),
        .wr_qid(cfg_qid), .wr_data(cfg_data), .quantum(quantum), .thresh(thresh)
    );

    // admission: fits under the threshold (inclusive) and a slot is free
    assign accept = enq_valid && !full &&
                    ((BYTE_W + 1)'(q_bytes[enq_qid]) + (BYTE_W + 1)'(enq_len)
                        <= (BYTE_W + 1)'(thresh[enq_qid]));

    wdrr_desc_store #(
        .NQ(NQ), .QW(QW), .DEPTH(DEPTH), .PW(PW), .CW(CW),
        .LEN_W(LEN_W), .HDL_W(HDL_W), .BYTE_W(BYTE_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .push_qid(enq_qid), .push_len(enq_len), .push_hdl(enq_hdl),
        .pop(pop), .pop_qid(cur),
        .head_len(head_len), .head_hdl(head_hdl), .q_pkts(q_pkts), .q_bytes(q_bytes),
        .free_map(free_map), .full(full)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_flags
        assign q_nonempty[g] = q_pkts[g] != '0;
        assign q_last[g]     = q_pkts[g] == CW'(1);
    end

    wdrr_sched #(
        .NQ(NQ), .QW(QW), .LEN_W(LEN_W), .QNT_W(QNT_W), .DEF_W(DEF_W)
    ) sched_i (
        .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .q_last(q_last),
        .head_len(head_len), .quantum(quantum), .push(accept), .push_qid(enq_qid),
        .deq_ready(deq_ready), .cur(cur), .deq_valid(deq_valid), .pop(pop)
    );

    assign deq_qid = cur;
    assign deq_len = head_len[cur];
    assign deq_hdl = head_hdl[cur];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_valid <= 1'b0;
            drop_qid   <= '0;
            drop_len   <= '0;
            drop_hdl   <= '0;
        end else begin
            drop_valid <= enq_valid && !accept;
            drop_qid   <= enq_qid;
            drop_len   <= enq_len;
            drop_hdl   <= enq_hdl;
        end
    end

endmodule

// File: rtl/wdrr_qmgr_chk.sv
module wdrr_qmgr_chk #(
    parameter int NQ     = 4,
    parameter int QW     = 2,
    parameter int DEPTH  = 16,
    parameter int CW     = 5,
    parameter int LEN_W  = 11,
    parameter int HDL_W  = 10,
    parameter int BYTE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enq_valid,
    input logic [HDL_W-1:0]  enq_hdl,
    input logic              deq_valid,
    input logic              deq_ready,
    input logic [QW-1:0]     deq_qid,
    input logic [LEN_W-1:0]  deq_len,
    input logic [HDL_W-1:0]  deq_hdl,
    input logic              drop_valid,
    input logic [HDL_W-1:0]  drop_hdl,
    input logic [CW-1:0]     q_pkts  [NQ],
    input logic [BYTE_W-1:0] q_bytes [NQ],
    input logic [DEPTH-1:0]  free_map
);
    int slot_total;

    always_comb begin
        slot_total = $countones(free_map);
        for (int q = 0; q < NQ; q++) slot_total += int'(q_pkts[q]);
    end

    a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid && !deq_ready |=> deq_valid);

    a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid && !deq_ready |=> $stable(deq_hdl) && $stable(deq_qid) && $stable(deq_len));

    a_r3_drop_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid |-> $past(enq_valid));

    a_r3_drop_handle: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid |-> drop_hdl == $past(enq_hdl));

    a_r4_slot_conservation: assert property (@(posedge clk) disable iff (!rst_n)
        slot_total == DEPTH);

    a_r7_no_empty_offer: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> q_pkts[deq_qid] != '0);

    for (genvar g = 0; g < NQ; g++) begin : g_q
        a_r11_empty_zero_bytes: assert property (@(posedge clk) disable iff (!rst_n)
            q_pkts[g] == '0 |-> q_bytes[g] == '0);
    end

endmodule

bind wdrr_qmgr wdrr_qmgr_chk #(
    .NQ(NQ), .QW(QW), .DEPTH(DEPTH), .CW(CW),
    .LEN_W(LEN_W), .HDL_W(HDL_W), .BYTE_W(BYTE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_hdl(enq_hdl),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_qid(deq_qid),
    .deq_len(deq_len), .deq_hdl(deq_hdl), .drop_valid(drop_valid),
    .drop_hdl(drop_hdl), .q_pkts(q_pkts), .q_bytes(q_bytes), .free_map(free_map)
);

// File: tb/wdrr_qmgr_tb_top.sv
`timescale 1ns/1ps
module wdrr_qmgr_tb_top;
    localparam int NQ = 4, QW = 2, DEPTH = 16, LEN_W = 11, HDL_W = 10, QNT_W = 10, BYTE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enq_valid = 1'b0;
    logic [QW-1:0]     enq_qid = '0;
    logic [LEN_W-1:0]  enq_len = '0;
    logic [HDL_W-1:0]  enq_hdl = '0;
    logic              cfg_we = 1'b0;
    logic              cfg_field = 1'b0;
    logic [QW-1:0]     cfg_qid = '0;
    logic [BYTE_W-1:0] cfg_data = '0;
    logic              deq_valid, deq_ready = 1'b0;
    logic [QW-1:0]     deq_qid;
    logic [LEN_W-1:0]  deq_len;
    logic [HDL_W-1:0]  deq_hdl;
    logic              drop_valid;
    logic [QW-1:0]     drop_qid;
    logic [LEN_W-1:0]  drop_len;
    logic [HDL_W-1:0]  drop_hdl;

    always #2.5 clk = ~clk;

    wdrr_qmgr #(.NQ(NQ), .DEPTH(DEPTH), .LEN_W(LEN_W), .HDL_W(HDL_W),
                .QNT_W(QNT_W), .BYTE_W(BYTE_W), .DEF_QUANTUM(64), .DEF_THRESH(1024)) dut_i (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_qid(enq_qid),
        .enq_len(enq_len), .enq_hdl(enq_hdl), .cfg_we(cfg_we), .cfg_field(cfg_field),
        .cfg_qid(cfg_qid), .cfg_data(cfg_data), .deq_valid(deq_valid), .deq_ready(deq_ready),
        .deq_qid(deq_qid), .deq_len(deq_len), .deq_hdl(deq_hdl), .drop_valid(drop_valid),
        .drop_qid(drop_qid), .drop_len(drop_len), .drop_hdl(drop_hdl)
    );

    int n_chk = 0, n_fail = 0;
    int m_qt[NQ], m_thr[NQ], m_bytes[NQ], m_def[NQ];
    int m_len[NQ][32], m_hdl[NQ][32], m_wr[NQ], m_rd[NQ];
    int m_total = 0;
    int e_q[64], e_len[64], e_hdl[64], e_n;
    int hdl_ctr = 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input bit field, input int q, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_field = field; cfg_qid = QW'(q); cfg_data = BYTE_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (field) m_thr[q] = val; else m_qt[q] = val;
    endtask

    task automatic enq(input int q, input int len, input string tag);
        bit exp_drop;
        int h;
        h = hdl_ctr;
        hdl_ctr = (hdl_ctr + 1) % 1024;
        exp_drop = (m_total == DEPTH) || (m_bytes[q] + len > m_thr[q]);
        @(negedge clk);
        enq_valid = 1'b1; enq_qid = QW'(q); enq_len = LEN_W'(len); enq_hdl = HDL_W'(h);
        @(negedge clk);
        enq_valid = 1'b0;
        check(drop_valid == exp_drop, {tag, " admit/drop decision"}, int'(drop_valid), int'(exp_drop));
        if (exp_drop) begin
            check(int'(drop_hdl) == h && int'(drop_qid) == q && int'(drop_len) == len,
                  "R3 drop fields", int'(drop_hdl), h);
        end else begin
            m_len[q][m_wr[q]] = len; m_hdl[q][m_wr[q]] = h; m_wr[q]++;
            m_bytes[q] += len; m_total++;
        end
    endtask

    function automatic int pick_next(input int c);
        for (int i = 1; i <= NQ; i++) begin
            if (m_wr[(c + i) % NQ] > m_rd[(c + i) % NQ]) return (c + i) % NQ;
        end
        return c;
    endfunction

    // reference WDRR order: queue 0 was credited first while the load was held back
    task automatic build_expected();
        int c, len;
        e_n = 0;
        c = 0;
        m_def[0] += m_qt[0];
        while (m_total > 0) begin
            len = m_len[c][m_rd[c]];
            if (m_wr[c] == m_rd[c]) begin
                m_def[c] = 0; c = pick_next(c); m_def[c] += m_qt[c];
            end else if (len <= m_def[c]) begin
                e_q[e_n] = c; e_len[e_n] = len; e_hdl[e_n] = m_hdl[c][m_rd[c]]; e_n++;
                m_def[c] -= len; m_rd[c]++; m_total--; m_bytes[c] -= len;
                if (m_wr[c] == m_rd[c]) begin
                    m_def[c] = 0;
                    if (m_total > 0) begin c = pick_next(c); m_def[c] += m_qt[c]; end
                end
            end else begin
                c = pick_next(c); m_def[c] += m_qt[c];
            end
        end
        for (int q = 0; q < NQ; q++) begin m_wr[q] = 0; m_rd[q] = 0; end
    endtask

    task automatic drain(input bit rnd_ready, input string tag);
        int k, guard, prev_hdl;
        bit prev_stall;
        build_expected();
        k = 0; guard = 0; prev_stall = 0; prev_hdl = 0;
        while (k < e_n && guard < 4000) begin
            @(negedge clk);
            deq_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
            #1;
            guard++;
            if (prev_stall)
                check(deq_valid && int'(deq_hdl) == prev_hdl, "R9 offer held under backpressure",
                      int'(deq_hdl), prev_hdl);
            prev_stall = deq_valid && !deq_ready;
            prev_hdl = int'(deq_hdl);
            if (deq_valid && deq_ready) begin
                check(int'(deq_qid) == e_q[k] && int'(deq_len) == e_len[k] && int'(deq_hdl) == e_hdl[k],
                      {tag, " R5 R6 R8 departure order (hdl)"}, int'(deq_hdl), e_hdl[k]);
                k++;
            end
        end
        @(negedge clk);
        deq_ready = 1'b0;
        check(k == e_n, "R9 one departure per handshake (count)", k, e_n);
        repeat (4) @(negedge clk);
        check(!deq_valid, "R7 nothing offered once all queues are empty", int'(deq_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int q = 0; q < NQ; q++) begin
            m_qt[q] = 64; m_thr[q] = 1024; m_bytes[q] = 0; m_def[q] = 0; m_wr[q] = 0; m_rd[q] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!deq_valid, "R1 deq_valid after reset", int'(deq_valid), 0);
        check(!drop_valid, "R1 drop_valid after reset", int'(drop_valid), 0);

        // R1 defaults: threshold 1024 admits exactly 1024 bytes, quantum 64
        enq(0, 10, "R1");
        enq(1, 1000, "R1");
        enq(1, 24, "R1");
        enq(1, 1, "R1");
        enq(2, 64, "R1");
        enq(2, 65, "R1");
        drain(1'b0, "R1");

        // R2 inclusive threshold, R10 threshold write
        cfg(1'b1, 1, 100);
        enq(0, 10, "R2");
        enq(1, 60, "R2");
        enq(1, 50, "R2");
        enq(1, 40, "R2");
        enq(1, 1, "R2");
        drain(1'b1, "R2");

        // R11 bytes released by departures
        enq(0, 5, "R11");
        enq(1, 100, "R11");
        drain(1'b0, "R11");

        // R4 slot pool exhaustion
        for (int q = 0; q < NQ; q++) cfg(1'b1, q, 4000);
        enq(0, 10, "R4");
        for (int i = 1; i < DEPTH + 2; i++) enq(i % NQ, 10, "R4");
        drain(1'b1, "R4");

        // R6 R8 R10 mixed quanta with heads that need two visits
        cfg(1'b0, 0, 30); cfg(1'b0, 1, 100); cfg(1'b0, 2, 50); cfg(1'b0, 3, 200);
        enq(0, 25, "R10");
        enq(0, 25, "R10"); enq(0, 25, "R10");
        enq(1, 60, "R10"); enq(1, 60, "R10");
        enq(2, 70, "R10"); enq(2, 20, "R10");
        enq(3, 10, "R10"); enq(3, 10, "R10"); enq(3, 10, "R10");
        drain(1'b0, "R6 R10");

        // randomised rounds
        for (int r = 0; r < 8; r++) begin
            for (int q = 0; q < NQ; q++) begin
                cfg(1'b0, q, 16 + int'($urandom % 112));
                cfg(1'b1, q, 100 + int'($urandom % 501));
            end
            enq(0, 1 + int'($urandom % 16), "R2");
            for (int i = 0; i < 20; i++)
                enq(int'($urandom % NQ), 1 + int'($urandom % 100), "R2 R4");
            drain(1'b1, "R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule